// File: doc/BRIEF.md
# Two-Tone AFSK Sample Generator

This block turns a stream of single data bits into an 8-bit unsigned audio sample stream. The stream carries the bits as two alternating tones: a 1200 Hz mark tone and a 2200 Hz space tone. A sample-rate strobe paces the block at 19200 samples per second. On each strobe, a 9-bit phase accumulator advances by the increment of the current tone. The accumulator addresses a 512-step sine cycle, and only one quarter of that cycle is held in a table. The block rebuilds the other three quarters by mirroring the table address and inverting the value read.

Bits arrive on a valid/ready handshake and are taken only at a bit boundary. Each bit lasts 16 samples. Encoding is NRZI-like: a 0 bit swaps the tone at the start of its period and a 1 bit keeps the tone. The phase carries on unbroken through every tone change. When no bit is offered at a boundary, the block sends mid-scale (128) and freezes its phase until data returns.

Top module: `afsk_tone_gen`

## Requirements
- R1: After reset, `sample_o` is 128, `tone_space_o` is 0 (mark) and the phase is 0.
- R2: The per-sample phase increment is round(512·f/19200): 32 for the mark tone and 59 for the space tone.
- R3: Quarter-table entry k (0..127) holds round(128 + 127·sin(2π(k+0.5)/512)), clamped to 128..255.
- R4: For phase p, the emitted value comes from table index q = p mod 256, replaced by 255−q when q ≥ 128. When p ≥ 256, the emitted value is 255 minus the table value.
- R5: The accumulator wraps modulo 512 and advances at most once per strobe. With no strobe, `sample_o` and `tone_space_o` hold.
- R6: `bit_ready_o` is high only in a cycle with `smp_stb_i` high, and only at a bit boundary. After a bit is accepted, the next boundary comes exactly 16 strobes later. `bit_valid_i` and `bit_i` have no effect mid-bit.
- R7: An accepted 0 bit swaps the tone (mark↔space) for its whole period. An accepted 1 bit keeps the tone. `tone_space_o` is 1 for space and 0 for mark.
- R8: The phase is continuous across a tone change. The new increment applies from the first advance of the bit that causes the change.
- R9: At a boundary strobe with no valid bit, `sample_o` becomes 128, the phase and tone do not change, and the boundary stays open.
- R10: On each active strobe, the registered sample is the sine of the phase before that strobe's advance. It appears on `sample_o` one clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_stb_i | input | 1 | One-cycle sample-rate strobe |
| bit_valid_i | input | 1 | Data bit offered |
| bit_i | input | 1 | Data bit, 0 swaps tone, 1 keeps tone |
| bit_ready_o | output | 1 | Bit taken this cycle when valid is also high |
| sample_o | output | 8 | Unsigned audio sample, 128 is silence |
| tone_space_o | output | 1 | Current tone, 1 = space, 0 = mark |

## Verification
The bench feeds a long pseudo-random bit stream with idle gaps at boundaries, so the phase sweeps through all four quadrants at both increments. A mirror or inversion error therefore shows up as a wrong sample in one quadrant, and an off-by-one in the increment rounding shows up as drift within a few samples. Bits held valid in the middle of a period would expose a bit counter that reopens the boundary early or late. An idle boundary would expose a design that keeps advancing its phase or emits a stale sample instead of mid-scale. A tone swap that reset the phase would break the sample sequence at the first space bit.

// File: rtl/afsk_pkg.sv
package afsk_pkg;
  function automatic int calc_inc(input int phase_w, input int freq_hz, input int rate_hz);
    longint num;
    num = (longint'(1) << phase_w) * longint'(freq_hz) + longint'(rate_hz / 2);
    return int'(num / longint'(rate_hz));
  endfunction

  function automatic int clog2_min1(input int v);
    int r;
    r = $clog2(v);
    return (r < 1) ? 1 : r;
  endfunction
endpackage

// File: rtl/afsk_qrom.sv
module afsk_qrom #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int  DEPTH  = 1 << ADDR_W;
  localparam int  MIDV   = 1 << (DATA_W - 1);
  localparam int  MAXV   = (1 << DATA_W) - 1;
  localparam real PI_R   = 3.14159265358979323846;
  localparam real CYCLE  = 4.0 * DEPTH;

  logic [DATA_W-1:0] rom [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_rom
    localparam real ANG = 2.0 * PI_R * (k + 0.5) / CYCLE;
    localparam int  RAW = $rtoi(MIDV + (MIDV - 1) * $sin(ANG) + 0.5);
    localparam int  VAL = (RAW < MIDV) ? MIDV : ((RAW > MAXV) ? MAXV : RAW);
    assign rom[k] = DATA_W'(VAL);
  end

  assign data_o = rom[addr_i];
endmodule

// File: rtl/afsk_sine_recon.sv
module afsk_sine_recon #(
  parameter int PHASE_W = 9,
  parameter int DATA_W  = 8
) (
  input  logic [PHASE_W-1:0] phase_i,
  output logic [DATA_W-1:0]  sine_o
);
  localparam int QA_W = PHASE_W - 2;

  logic [QA_W-1:0]   q_addr;
  logic [DATA_W-1:0] q_val;

  // second/fourth quarter run the table backwards: 255-q == ~low bits
  assign q_addr = phase_i[PHASE_W-2] ? ~phase_i[QA_W-1:0] : phase_i[QA_W-1:0];

  afsk_qrom #(.ADDR_W(QA_W), .DATA_W(DATA_W)) i_qrom (
    .addr_i (q_addr),
    .data_o (q_val)
  );

  // lower half cycle: full-scale minus value == bitwise invert
  assign sine_o = phase_i[PHASE_W-1] ? ~q_val : q_val;
endmodule

// File: rtl/afsk_bit_timer.sv
module afsk_bit_timer #(
  parameter int SPB = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic valid_i,
  output logic ready_o,
  output logic fire_o,
  output logic run_o
);
  localparam int CNT_W = afsk_pkg::clog2_min1(SPB);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(SPB - 1);
  localparam logic [CNT_W-1:0] FIRST = (SPB == 1) ? '0 : CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             boundary;

  assign boundary = (cnt_q == '0);
  assign ready_o  = stb_i & boundary;
  assign fire_o   = ready_o & valid_i;
  assign run_o    = stb_i & (~boundary | valid_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (stb_i) begin
      if (boundary) begin
        if (valid_i) cnt_q <= FIRST;
      end else if (cnt_q == LAST) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/afsk_tone_sel.sv
module afsk_tone_sel #(
  parameter int PHASE_W   = 9,
  parameter int MARK_INC  = 32,
  parameter int SPACE_INC = 59
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic               bit_i,
  output logic [PHASE_W-1:0] inc_o,
  output logic               tone_space_o
);
  localparam logic [PHASE_W-1:0] MARK_V  = PHASE_W'(MARK_INC);
  localparam logic [PHASE_W-1:0] SPACE_V = PHASE_W'(SPACE_INC);

  logic [PHASE_W-1:0] inc_q;
  logic [PHASE_W-1:0] swapped;

  assign swapped = (inc_q == MARK_V) ? SPACE_V : MARK_V;
  assign inc_o   = (fire_i && !bit_i) ? swapped : inc_q;
  assign tone_space_o = (inc_q == SPACE_V);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     inc_q <= MARK_V;
    else if (fire_i) inc_q <= inc_o;
  end
endmodule

// File: rtl/afsk_tone_gen.sv
module afsk_tone_gen #(
  parameter int SAMPLE_HZ = 19200,
  parameter int BIT_HZ    = 1200,
  parameter int MARK_HZ   = 1200,
  parameter int SPACE_HZ  = 2200,
  parameter int PHASE_W   = 9,
  parameter int DATA_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_stb_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  output logic              bit_ready_o,
  output logic [DATA_W-1:0] sample_o,
  output logic              tone_space_o
);
  localparam int SPB       = SAMPLE_HZ / BIT_HZ;
  localparam int MARK_INC  = afsk_pkg::calc_inc(PHASE_W, MARK_HZ, SAMPLE_HZ);
  localparam int SPACE_INC = afsk_pkg::calc_inc(PHASE_W, SPACE_HZ, SAMPLE_HZ);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));

  logic               fire, run;
  logic [PHASE_W-1:0] inc, phase_q;
  logic [DATA_W-1:0]  sine;

  afsk_bit_timer #(.SPB(SPB)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stb_i   (smp_stb_i),
    .valid_i (bit_valid_i),
    .ready_o (bit_ready_o),
    .fire_o  (fire),
    .run_o   (run)
  );

  afsk_tone_sel #(.PHASE_W(PHASE_W), .MARK_INC(MARK_INC), .SPACE_INC(SPACE_INC)) i_tone (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fire_i       (fire),
    .bit_i        (bit_i),
    .inc_o        (inc),
    .tone_space_o (tone_space_o)
  );

  afsk_sine_recon #(.PHASE_W(PHASE_W), .DATA_W(DATA_W)) i_recon (
    .phase_i (phase_q),
    .sine_o  (sine)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q  <= '0;
      sample_o <= MID;
    end else if (smp_stb_i) begin
      if (run) begin
        sample_o <= sine;
        phase_q  <= phase_q + inc;  // wraps modulo 2**PHASE_W
      end else begin
        sample_o <= MID;
      end
    end
  end
endmodule

// File: rtl/afsk_tone_gen_chk.sv
module afsk_tone_gen_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              smp_stb_i,
  input logic              bit_valid_i,
  input logic              bit_i,
  input logic              bit_ready_o,
  input logic [DATA_W-1:0] sample_o,
  input logic              tone_space_o
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1 << (DATA_W - 1));
  logic fire;
  assign fire = bit_valid_i & bit_ready_o;

  a_r6_ready_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_ready_o |-> smp_stb_i);

  a_r9_idle_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_ready_o && !bit_valid_i) |=> (sample_o == MID));

  a_r9_idle_keeps_tone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire |=> $stable(tone_space_o));

  a_r7_one_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && bit_i) |=> $stable(tone_space_o));

  a_r7_zero_swaps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !bit_i) |=> (tone_space_o != $past(tone_space_o)));

  a_r5_hold_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_stb_i |=> $stable(sample_o));
endmodule

bind afsk_tone_gen afsk_tone_gen_chk #(.DATA_W(DATA_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .smp_stb_i    (smp_stb_i),
  .bit_valid_i  (bit_valid_i),
  .bit_i        (bit_i),
  .bit_ready_o  (bit_ready_o),
  .sample_o     (sample_o),
  .tone_space_o (tone_space_o)
);

// File: tb/test_afsk_tone_gen.sv
module test_afsk_tone_gen;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       smp_stb_i = 1'b0;
  logic       bit_valid_i = 1'b0;
  logic       bit_i = 1'b0;
  logic       bit_ready_o;
  logic [7:0] sample_o;
  logic       tone_space_o;

  int checks = 0;
  int fails = 0;

  // bench model state
  int m_phase = 0;
  int m_inc = 32;
  int m_cnt = 0;
  int m_sample = 128;
  logic [7:0] lfsr = 8'hA5;

  always #2.5 clk = ~clk;

  afsk_tone_gen i_afsk_tone_gen (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .smp_stb_i    (smp_stb_i),
    .bit_valid_i  (bit_valid_i),
    .bit_i        (bit_i),
    .bit_ready_o  (bit_ready_o),
    .sample_o     (sample_o),
    .tone_space_o (tone_space_o)
  );

  function automatic int exp_sine(input int p);
    int q, v;
    real a;
    q = p % 256;
    if (q >= 128) q = 255 - q;
    a = 2.0 * 3.14159265358979323846 * (q + 0.5) / 512.0;
    v = $rtoi(128.0 + 127.0 * $sin(a) + 0.5);
    if (v < 128) v = 128;
    if (v > 255) v = 255;
    return (p >= 256) ? 255 - v : v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one strobe, then gap idle cycles with hold checks
  task automatic strobe(input bit v, input bit b, input int gap);
    bit bnd;
    @(negedge clk);
    smp_stb_i = 1'b1; bit_valid_i = v; bit_i = b;
    #0.5;
    bnd = (m_cnt == 0);
    check("R6 ready at boundary only", int'(bit_ready_o), int'(bnd));
    if (bnd && !v) begin
      m_sample = 128;                      // R9
    end else begin
      if (bnd) begin
        if (!b) m_inc = (m_inc == 32) ? 59 : 32;  // R7
        m_cnt = 1;
      end else begin
        m_cnt = (m_cnt + 1) % 16;          // R6
      end
      m_sample = exp_sine(m_phase);        // R10 R4 R3
      m_phase = (m_phase + m_inc) % 512;   // R2 R5 R8
    end
    @(negedge clk);
    smp_stb_i = 1'b0; bit_valid_i = 1'b0; bit_i = 1'b0;
    check("R10 R4 R8 sample", int'(sample_o), m_sample);
    check("R7 tone", int'(tone_space_o), int'(m_inc == 59));
    for (int g = 0; g < gap; g++) begin
      bit_valid_i = 1'b1; bit_i = g[0];
      @(negedge clk);
      check("R5 hold without strobe", int'(sample_o), m_sample);
    end
    bit_valid_i = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset sample", int'(sample_o), 128);
    check("R1 reset tone", int'(tone_space_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R9: idle boundaries, phase frozen
    strobe(1'b0, 1'b0, 1);
    strobe(1'b0, 1'b1, 0);

    // R2: first bit mark, samples at 0,32,64,...
    for (int s = 0; s < 16; s++) strobe(s == 0, 1'b1, 0);
    check("R2 mark phase after one bit", m_phase, 0);

    // R7 R8: swap to space, then wider sweep
    for (int s = 0; s < 16; s++) strobe(s == 0, 1'b0, s % 3);

    for (int n = 0; n < 220; n++) begin
      bit nb;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      nb = lfsr[0];
      if (lfsr[3:1] == 3'd5) strobe(1'b0, nb, 1);  // R9 gap at boundary
      for (int s = 0; s < 16; s++)
        strobe(1'b1, (s == 0) ? nb : ~nb, (n + s) % 2); // R6 mid-bit valid ignored
    end

    // R3: first-quarter entries reached through the sweep, plus endpoints
    check("R3 entry 0", exp_sine(0), 129);
    check("R3 entry 127", exp_sine(127), 255);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule